// File: doc/BRIEF.md
# Record-then-Playback Sample Buffer Controller

This block runs a small data acquisition buffer. After a start request it records one sample word per step from a converter-style input port. Each word goes into the next location of an internal synchronous RAM, from location zero up to the last one. When the address counter reaches its terminal count, the controller waits for one guard cycle with no strobes. It then replays the same locations in the same order. Each replayed word appears on an output port with a valid flag, ready for a converter on the output side.

Every step lasts two clock cycles. In the first cycle the address and data settle. In the second cycle, the late phase, the write or read strobe is asserted. The write strobe is the record mode ANDed with the late phase, so it is never high while the address is changing. The address counter is built from cascaded stages joined by a carry chain. Its ripple carry at the terminal count ends each pass. A one-cycle pulse marks the end of playback, and the controller then sits idle until the next start.

Top module: `rec_play_buf`

## Requirements
- R1: Synchronous active-high reset. While it is applied and in the cycle after it, addr_o is 0 and wr_en_o, rd_en_o, play_valid_o, done_o, recording_o and playing_o are all 0.
- R2: A start_i high at a clock edge while idle sets recording_o in the next cycle. The first write strobe follows one cycle later, at address 0.
- R3: wr_en_o is never high in two consecutive cycles. In every cycle where it is high, addr_o holds the value it had in the previous cycle.
- R4: Write strobes visit addresses 0, 1, 2 … DEPTH-1 in that order, one per two-cycle step. Read strobes later visit the same addresses in the same order.
- R5: In the cycle after the strobe at address DEPTH-1, recording_o, playing_o, wr_en_o and rd_en_o are all 0 (the turnaround). In the cycle after that, playing_o is 1 and rd_en_o is still 0. No write happens at the first playback address.
- R6: wr_en_o and rd_en_o are never high in the same cycle.
- R7: play_valid_o is high exactly in the cycle after each rd_en_o cycle.
- R8: The words shown on play_data_o while play_valid_o is high are the recorded samples, in recording order, DEPTH words in total.
- R9: done_o is high for one cycle, together with the last valid word. After that, no strobe occurs and recording_o and playing_o stay 0 until the next start.
- R10: start_i has no effect while recording or playing. The address sequence and the stored data continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a record pass (only acted on while idle) |
| sample_i | input | DATA_W | Sample word from the input converter |
| wr_en_o | output | 1 | Write strobe, late phase of a record step |
| rd_en_o | output | 1 | Read strobe, late phase of a playback step |
| addr_o | output | ADDR_W | Current RAM address |
| play_data_o | output | DATA_W | Replayed word for the output converter |
| play_valid_o | output | 1 | play_data_o carries a new word |
| done_o | output | 1 | One-cycle pulse at the end of playback |
| recording_o | output | 1 | Record pass in progress |
| playing_o | output | 1 | Playback pass in progress |

## Verification
The sample that gets stored is whatever sample_i holds in the cycle when wr_en_o is high. The bench therefore captures that value at the falling edge of the strobe cycle and pushes it into a queue. Each replayed word is due one cycle after its read strobe, so the monitor pops the queue only when it sees play_valid_o, and it checks that the previous cycle had rd_en_o high. The first write strobe is checked exactly two cycles after the edge that samples start_i. The turnaround is checked in the first cycle after recording_o falls, and the start of playback in the cycle after that. All outputs are sampled on the falling clock edge, and inputs change just after the rising edge.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

    localparam int DEF_DATA_W  = 8;
    localparam int DEF_DEPTH   = 256;
    localparam int DEF_STAGE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_TURN = 2'd2,
        ST_PLAY = 2'd3
    } ctl_state_e;

    typedef struct packed {
        logic late;
        logic wr;
        logic rd;
    } strobe_t;

    function automatic int stage_count(input int addr_w, input int stage_w);
        return (addr_w + stage_w - 1) / stage_w;
    endfunction

endpackage

// File: rtl/rpb_addr_ctr.sv
module rpb_addr_ctr #(
    parameter int ADDR_W  = 8,
    parameter int STAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] count_o,
    output logic              rco_o
);
    localparam int NSTG = rpb_pkg::stage_count(ADDR_W, STAGE_W);

    logic [NSTG:0]     carry;
    logic [NSTG:0]     term;
    logic [ADDR_W-1:0] cnt;

    assign carry[0] = step_i;
    assign term[0]  = 1'b1;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        localparam int LO = g * STAGE_W;
        localparam int HI = ((LO + STAGE_W) > ADDR_W) ? ADDR_W - 1 : LO + STAGE_W - 1;
        logic [HI-LO:0] stg_q;

        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                stg_q <= '0;
            end else if (carry[g]) begin
                stg_q <= stg_q + 1'b1;
            end
        end

        assign cnt[HI:LO]  = stg_q;
        // stage advances its neighbour only when it is at its own terminal count
        assign carry[g+1]  = carry[g] & (&stg_q);
        assign term[g+1]   = term[g] & (&stg_q);
    end

    assign count_o = cnt;
    assign rco_o   = term[NSTG];
endmodule

// File: rtl/rpb_strobe_gen.sv
module rpb_strobe_gen (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             rec_i,
    output rpb_pkg::strobe_t stb_o
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= !phase_q;
        end
    end

    always_comb begin
        stb_o.late = phase_q;
        stb_o.wr   = run_i &  rec_i & phase_q;
        stb_o.rd   = run_i & !rec_i & phase_q;
    end
endmodule

// File: rtl/rpb_sram.sv
module rpb_sram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (re_i) begin
            rdata_o <= mem[addr_i];
        end
    end
endmodule

// File: rtl/rec_play_buf.sv
module rec_play_buf #(
    parameter int DATA_W  = rpb_pkg::DEF_DATA_W,
    parameter int DEPTH   = rpb_pkg::DEF_DEPTH,
    parameter int STAGE_W = rpb_pkg::DEF_STAGE_W,
    parameter int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              wr_en_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] play_data_o,
    output logic              play_valid_o,
    output logic              done_o,
    output logic              recording_o,
    output logic              playing_o
);
    import rpb_pkg::*;

    ctl_state_e        state_q;
    strobe_t           stb;
    logic              rco;
    logic              clr;
    logic [ADDR_W-1:0] addr;
    logic              valid_q;
    logic              done_q;

    assign clr = (state_q == ST_IDLE) && start_i;

    rpb_addr_ctr #(
        .ADDR_W  (ADDR_W),
        .STAGE_W (STAGE_W)
    ) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (clr),
        .step_i  (stb.wr | stb.rd),
        .count_o (addr),
        .rco_o   (rco)
    );

    rpb_strobe_gen stb_i (
        .clk   (clk),
        .rst   (rst),
        .run_i ((state_q == ST_REC) || (state_q == ST_PLAY)),
        .rec_i (state_q == ST_REC),
        .stb_o (stb)
    );

    rpb_sram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) ram_i (
        .clk     (clk),
        .rst     (rst),
        .we_i    (stb.wr),
        .re_i    (stb.rd),
        .addr_i  (addr),
        .wdata_i (sample_i),
        .rdata_o (play_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i)        state_q <= ST_REC;
                ST_REC:  if (stb.wr && rco)  state_q <= ST_TURN;
                ST_TURN:                     state_q <= ST_PLAY;
                ST_PLAY: if (stb.rd && rco)  state_q <= ST_IDLE;
                default:                     state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= stb.rd;
            done_q  <= stb.rd & rco;
        end
    end

    assign wr_en_o      = stb.wr;
    assign rd_en_o      = stb.rd;
    assign addr_o       = addr;
    assign play_valid_o = valid_q;
    assign done_o       = done_q;
    assign recording_o  = (state_q == ST_REC);
    assign playing_o    = (state_q == ST_PLAY);
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en_o,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              play_valid_o,
    input logic              done_o,
    input logic              recording_o,
    input logic              playing_o
);
    assert_wr_no_repeat_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o);

    assert_wr_addr_settled_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $stable(addr_o));

    assert_no_dual_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_o && rd_en_o));

    assert_turn_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(recording_o) |-> (!wr_en_o && !rd_en_o && !playing_o));

    assert_turn_to_play_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(recording_o) |=> (playing_o && !rd_en_o));

    assert_valid_follows_read_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en_o |=> play_valid_o);

    assert_valid_has_read_R7: assert property (@(posedge clk) disable iff (rst)
        play_valid_o |-> $past(rd_en_o));

    assert_done_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> play_valid_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !playing_o && !rd_en_o));
endmodule

bind rec_play_buf rpb_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en_o      (wr_en_o),
    .rd_en_o      (rd_en_o),
    .addr_o       (addr_o),
    .play_valid_o (play_valid_o),
    .done_o       (done_o),
    .recording_o  (recording_o),
    .playing_o    (playing_o)
);

// File: tb/rec_play_buf_tb_top.sv
module rec_play_buf_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 256;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [DATA_W-1:0] sample_i = '0;
    logic              wr_en_o, rd_en_o, play_valid_o, done_o, recording_o, playing_o;
    logic [ADDR_W-1:0] addr_o;
    logic [DATA_W-1:0] play_data_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int seed = 1;

    logic [DATA_W-1:0] exp_q[$];
    int  exp_wr_addr = 0;
    int  exp_rd_addr = 0;
    int  valid_cnt = 0;
    logic prev_wr = 1'b0;
    logic prev_rd = 1'b0;
    logic prev_rec = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic turn_next = 1'b0;
    logic done_next = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rec_play_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sample_i(sample_i),
        .wr_en_o(wr_en_o), .rd_en_o(rd_en_o), .addr_o(addr_o),
        .play_data_o(play_data_o), .play_valid_o(play_valid_o), .done_o(done_o),
        .recording_o(recording_o), .playing_o(playing_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // sample source: a new word every cycle, changed just after the rising edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 sample_i <= DATA_W'((cyc * 37) + (seed * 11) + (cyc >> 3));
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en_o || rd_en_o)
                check(!(wr_en_o && rd_en_o), "R6 dual strobe", {wr_en_o, rd_en_o}, 0);
            if (wr_en_o) begin
                check(!prev_wr, "R3 consecutive write", prev_wr, 0);
                check(prev_addr == addr_o, "R3 address moved at write", addr_o, prev_addr);
                check(int'(addr_o) == exp_wr_addr, "R4 write address", addr_o, exp_wr_addr);
                exp_q.push_back(sample_i);
                exp_wr_addr++;
            end
            if (rd_en_o) begin
                check(int'(addr_o) == exp_rd_addr, "R4 read address", addr_o, exp_rd_addr);
                exp_rd_addr++;
            end
            if (play_valid_o) begin
                logic [DATA_W-1:0] e;
                check(prev_rd, "R7 valid without read one cycle earlier", prev_rd, 1);
                e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
                check(play_data_o == e, "R8 playback word", play_data_o, e);
                valid_cnt++;
            end else begin
                if (prev_rd) check(1'b0, "R7 missing valid after read", 0, 1);
            end
            if (turn_next) begin
                check(playing_o && !rd_en_o && !wr_en_o, "R5 playback entry", playing_o, 1);
                turn_next = 1'b0;
            end
            if (prev_rec && !recording_o) begin
                check(!wr_en_o && !rd_en_o && !playing_o, "R5 turnaround quiet",
                      {wr_en_o, rd_en_o, playing_o}, 0);
                check(exp_wr_addr == DEPTH, "R4 writes per pass", exp_wr_addr, DEPTH);
                turn_next = 1'b1;
            end
            if (done_next) begin
                check(!done_o && !playing_o && !recording_o, "R9 after done",
                      {done_o, playing_o, recording_o}, 0);
                done_next = 1'b0;
            end
            if (done_o) begin
                check(play_valid_o, "R9 done with last word", play_valid_o, 1);
                check(valid_cnt == DEPTH, "R8 word count", valid_cnt, DEPTH);
                check(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);
                done_next = 1'b1;
            end
        end
        prev_wr   = wr_en_o;
        prev_rd   = rd_en_o;
        prev_rec  = recording_o;
        prev_addr = addr_o;
    end

    task automatic run_pass(input int s);
        int quiet_bad;
        seed = s;
        exp_wr_addr = 0;
        exp_rd_addr = 0;
        valid_cnt = 0;
        exp_q.delete();
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;   // start sampled at this edge
        @(negedge clk);
        check(recording_o && !wr_en_o, "R2 record entry", {recording_o, wr_en_o}, 2);
        @(negedge clk);
        check(wr_en_o && addr_o == 0, "R2 first write at address 0", addr_o, 0);
        // start while recording is ignored
        while (addr_o != ADDR_W'(100)) @(negedge clk);
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        @(negedge clk);
        check(recording_o && addr_o >= ADDR_W'(100), "R10 start during record", addr_o, 100);
        // start while playing is ignored
        while (!(playing_o && addr_o == ADDR_W'(40))) @(negedge clk);
        @(posedge clk); #1 start_i = 1'b1;
        @(posedge clk); #1 start_i = 1'b0;
        @(negedge clk);
        check(playing_o && !recording_o && addr_o >= ADDR_W'(40), "R10 start during playback",
              addr_o, 40);
        while (!done_o) @(negedge clk);
        quiet_bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (wr_en_o || rd_en_o || recording_o || playing_o) quiet_bad++;
        end
        check(quiet_bad == 0, "R9 idle after done", quiet_bad, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(addr_o == 0 && !wr_en_o && !rd_en_o && !play_valid_o && !done_o
              && !recording_o && !playing_o, "R1 state in reset", addr_o, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(addr_o == 0 && !wr_en_o && !rd_en_o && !play_valid_o && !done_o
              && !recording_o && !playing_o, "R1 state after reset", addr_o, 0);
        run_pass(1);
        run_pass(5);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end
endmodule